// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block holds the status and control word of one downstream port of a USB root hub. It keeps the port's connect, enable, suspend, reset, power and low-speed state, together with five sticky change flags. Two kinds of input update the word. The port side reports device attach and detach, and an attach carries a low-speed flag. The software side writes a 32-bit value. Most bits of that value are commands rather than plain data, and a 1 in a given position means something different from the bit that position reads back as.

Requests to enable, suspend or reset the port are conditional. They take effect only while a device is connected. On an empty port they leave the bit alone and set the connect-change flag instead, so that software learns the device has gone. A port reset has no duration: it completes in the same update. The enable bit and the reset-change flag set, and the reset bit never reads back as 1.

Any update that alters the stored word produces a one-cycle status-change pulse for the hub's interrupt logic. One instance is built per port.

Top module: `usb_rh_port_reg`

## Requirements
- R1: After reset, every bit of `port_reg` is 0 and `chg_evt` is 0.
- R2: An attach sets the connect bit (bit 0) and the connect-change bit (bit 16), and copies `attach_low_speed` into the low-speed bit (bit 9).
- R3: A detach clears a set connect bit and sets connect-change (bit 16). It also clears a set enable bit (bit 1) and sets enable-change (bit 17). A bit that was already 0 raises no change flag.
- R4: Writing 1 to any of bits 16 to 20 (connect, enable, suspend, overcurrent and reset change, in that order) clears that flag. Writing 0 leaves it unchanged.
- R5: Writing 1 to bit 0 clears the enable bit (bit 1).
- R6: Writing 1 to bit 1 (enable) or bit 2 (suspend) sets that bit when the connect bit is 1. When the connect bit is 0, the requested bit stays unchanged and the connect-change bit (bit 16) sets.
- R7: Writing 1 to bit 4 (reset) on a connected port sets the enable bit and the reset-change bit (bit 20), and leaves the reset bit (bit 4) at 0. On a disconnected port, the same write only sets connect-change.
- R8: Writing 1 to bit 9 clears the power (bit 8), connect, suspend and reset bits. Writing 1 to bit 8 sets the power bit. When both bits are written in the same cycle, the port ends with power on.
- R9: `chg_evt` is 1 in exactly those cycles in which `port_reg` differs from its value one cycle earlier.
- R10: When a write and a port event fall in the same cycle, the write is applied first. The detach is applied to that result, and the attach is applied last.
- R11: The overcurrent bit (bit 3), the overcurrent-change bit (bit 19) and bits 5-7, 10-15 and 21-31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value (command bits) |
| attach | input | 1 | Device attached to the port this cycle |
| detach | input | 1 | Device removed from the port this cycle |
| attach_low_speed | input | 1 | Speed of the attaching device, 1 for low speed |
| port_reg | output | 32 | Current status and control word |
| chg_evt | output | 1 | One-cycle pulse when the word has changed |

## Verification
Every result is due one clock edge after its stimulus. The inputs are applied before a rising edge, and both `port_reg` and `chg_evt` show the outcome once that edge has passed. The bench drives its inputs on the falling edge and samples the outputs on the next falling edge. There it compares them with a model word that it advances once per edge, so every comparison falls in the single cycle where the result first appears. Directed steps set up each conditional case: requests on an empty port, a reset on a connected port, power commands written together, and a write coinciding with an attach. A long random run then mixes writes and port events.

// File: rtl/usb_rh_port_pkg.sv
package usb_rh_port_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned NUM_CHG  = 5;
    localparam int unsigned CHG_LO   = 16;

    // Bit positions of the status word (software and driver decode these)
    localparam int unsigned B_CONN   = 0;
    localparam int unsigned B_ENA    = 1;
    localparam int unsigned B_SUSP   = 2;
    localparam int unsigned B_OVC    = 3;
    localparam int unsigned B_RST    = 4;
    localparam int unsigned B_PWR    = 8;
    localparam int unsigned B_LOWSPD = 9;

    // Index of each flag inside the change vector
    localparam int unsigned C_CONN   = 0;
    localparam int unsigned C_ENA    = 1;
    localparam int unsigned C_SUSP   = 2;
    localparam int unsigned C_OVC    = 3;
    localparam int unsigned C_RST    = 4;

    typedef struct packed {
        logic               low_spd;
        logic               powered;
        logic               in_reset;
        logic               ovc;
        logic               suspended;
        logic               enabled;
        logic               connected;
        logic [NUM_CHG-1:0] chg;
    } port_state_t;

    localparam port_state_t PORT_STATE_RST = '0;

endpackage

// File: rtl/usb_rh_port_wr.sv
// Applies one software write to the port state.
module usb_rh_port_wr
    import usb_rh_port_pkg::*;
(
    input  port_state_t          cur_i,
    input  logic                 wr_en_i,
    input  logic [REG_W-1:0]     wdata_i,
    output port_state_t          nxt_o
);

    localparam int unsigned NUM_REQ = 3;

    logic [NUM_CHG-1:0] clr_mask;
    logic [NUM_REQ-1:0] req;
    logic [NUM_REQ-1:0] grant;
    logic               miss;
    logic               unused_wbits;

    assign clr_mask = wdata_i[CHG_LO +: NUM_CHG];
    assign req      = {wdata_i[B_RST], wdata_i[B_SUSP], wdata_i[B_ENA]};

    // A conditional request is granted only on a connected port.
    // Any request on an empty port flags a connect change.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        assign grant[g] = req[g] & cur_i.connected;
    end
    assign miss = (|req) & ~cur_i.connected;

    assign unused_wbits = ^{wdata_i[REG_W-1:CHG_LO+NUM_CHG],
                            wdata_i[CHG_LO-1:B_LOWSPD+1],
                            wdata_i[B_PWR-1:B_RST+1],
                            wdata_i[B_OVC]};

    always_comb begin
        nxt_o = cur_i;
        if (wr_en_i) begin
            nxt_o.chg = nxt_o.chg & ~clr_mask;
            if (wdata_i[B_CONN]) begin
                nxt_o.enabled = 1'b0;
            end
            if (miss) begin
                nxt_o.chg[C_CONN] = 1'b1;
            end
            if (grant[0]) begin
                nxt_o.enabled = 1'b1;
            end
            if (grant[1]) begin
                nxt_o.suspended = 1'b1;
            end
            if (grant[2]) begin
                // reset finishes at once
                nxt_o.in_reset   = 1'b0;
                nxt_o.enabled    = 1'b1;
                nxt_o.chg[C_RST] = 1'b1;
            end
            if (wdata_i[B_LOWSPD]) begin
                nxt_o.powered   = 1'b0;
                nxt_o.connected = 1'b0;
                nxt_o.suspended = 1'b0;
                nxt_o.in_reset  = 1'b0;
            end
            if (wdata_i[B_PWR]) begin
                nxt_o.powered = 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_rh_port_link.sv
// Applies port-side attach and detach after the software write.
module usb_rh_port_link
    import usb_rh_port_pkg::*;
(
    input  port_state_t cur_i,
    input  logic        attach_i,
    input  logic        detach_i,
    input  logic        low_spd_i,
    output port_state_t nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (detach_i) begin
            if (nxt_o.connected) begin
                nxt_o.connected   = 1'b0;
                nxt_o.chg[C_CONN] = 1'b1;
            end
            if (nxt_o.enabled) begin
                nxt_o.enabled    = 1'b0;
                nxt_o.chg[C_ENA] = 1'b1;
            end
        end
        if (attach_i) begin
            nxt_o.connected   = 1'b1;
            nxt_o.chg[C_CONN] = 1'b1;
            nxt_o.low_spd     = low_spd_i;
        end
    end

endmodule

// File: rtl/usb_rh_port_pack.sv
// Places the state fields at their bit positions in the status word.
module usb_rh_port_pack
    import usb_rh_port_pkg::*;
(
    input  port_state_t      st_i,
    output logic [REG_W-1:0] word_o
);

    logic [REG_W-1:0] base;

    always_comb begin
        base           = '0;
        base[B_CONN]   = st_i.connected;
        base[B_ENA]    = st_i.enabled;
        base[B_SUSP]   = st_i.suspended;
        base[B_OVC]    = st_i.ovc;
        base[B_RST]    = st_i.in_reset;
        base[B_PWR]    = st_i.powered;
        base[B_LOWSPD] = st_i.low_spd;
    end

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g >= CHG_LO && g < CHG_LO + NUM_CHG) begin : g_chg
            assign word_o[g] = st_i.chg[g - CHG_LO];
        end else begin : g_base
            assign word_o[g] = base[g];
        end
    end

endmodule

// File: rtl/usb_rh_port_reg.sv
module usb_rh_port_reg
    import usb_rh_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             attach,
    input  logic             detach,
    input  logic             attach_low_speed,
    output logic [31:0]      port_reg,
    output logic             chg_evt
);

    typedef struct packed {
        port_state_t st;
        logic        evt;
    } reg_t;

    reg_t        r_d, r_q;
    port_state_t after_wr;
    port_state_t after_link;

    usb_rh_port_wr u_wr (
        .cur_i   (r_q.st),
        .wr_en_i (wr_en),
        .wdata_i (wr_data),
        .nxt_o   (after_wr)
    );

    usb_rh_port_link u_link (
        .cur_i     (after_wr),
        .attach_i  (attach),
        .detach_i  (detach),
        .low_spd_i (attach_low_speed),
        .nxt_o     (after_link)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = after_link;
        r_d.evt = (after_link != r_q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: PORT_STATE_RST, evt: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    usb_rh_port_pack u_pack (
        .st_i   (r_q.st),
        .word_o (port_reg)
    );

    assign chg_evt = r_q.evt;

endmodule

// File: rtl/usb_rh_port_reg_chk.sv
module usb_rh_port_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        attach,
    input logic        detach,
    input logic        attach_low_speed,
    input logic [31:0] port_reg,
    input logic        chg_evt
);

    // R9
    evt_tracks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt == (port_reg != $past(port_reg)));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_reg & 32'hFFE8_FCE8) == 32'h0);

    // R7
    reset_never_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_reg[4]);

    // R2
    attach_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attach |=> port_reg[0] && port_reg[16] && (port_reg[9] == $past(attach_low_speed)));

    // R8
    power_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[8]) |=> port_reg[8]);

    // R4
    ena_chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[17] && !detach) |=> !port_reg[17]);

    // R6
    empty_req_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && !port_reg[0] && !attach) |=> port_reg[16]);

endmodule

bind usb_rh_port_reg usb_rh_port_reg_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .attach           (attach),
    .detach           (detach),
    .attach_low_speed (attach_low_speed),
    .port_reg         (port_reg),
    .chg_evt          (chg_evt)
);

// File: tb/usb_rh_port_reg_tb.sv
module usb_rh_port_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        attach = 1'b0;
    logic        detach = 1'b0;
    logic        attach_low_speed = 1'b0;
    logic [31:0] port_reg;
    logic        chg_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    usb_rh_port_reg u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .attach           (attach),
        .detach           (detach),
        .attach_low_speed (attach_low_speed),
        .port_reg         (port_reg),
        .chg_evt          (chg_evt)
    );

    // Expected next word, built from the requirements
    function automatic logic [31:0] next_word(input logic [31:0] r, input bit we,
                                              input logic [31:0] w, input bit at,
                                              input bit de, input bit ls);
        logic [31:0] v;
        v = r;
        if (we) begin
            v[20:16] = v[20:16] & ~w[20:16];
            if (w[0]) v[1] = 1'b0;
            if (w[1]) begin if (v[0]) v[1] = 1'b1; else v[16] = 1'b1; end
            if (w[2]) begin if (v[0]) v[2] = 1'b1; else v[16] = 1'b1; end
            if (w[4]) begin
                if (v[0]) begin v[1] = 1'b1; v[20] = 1'b1; end
                else v[16] = 1'b1;
            end
            if (w[9]) begin v[8] = 1'b0; v[0] = 1'b0; v[2] = 1'b0; v[4] = 1'b0; end
            if (w[8]) v[8] = 1'b1;
        end
        if (de) begin
            if (v[0]) begin v[0] = 1'b0; v[16] = 1'b1; end
            if (v[1]) begin v[1] = 1'b0; v[17] = 1'b1; end
        end
        if (at) begin v[0] = 1'b1; v[16] = 1'b1; v[9] = ls; end
        return v;
    endfunction

    task automatic compare(input string tag, input logic [31:0] exp_w, input bit exp_e);
        n_chk++;
        if (port_reg !== exp_w) begin
            n_bad++;
            $display("FAIL %s port_reg actual=%h expected=%h", tag, port_reg, exp_w);
        end
        n_chk++;
        if (chg_evt !== exp_e) begin
            n_bad++;
            $display("FAIL %s chg_evt actual=%b expected=%b", tag, chg_evt, exp_e);
        end
    endtask

    // Called at a falling edge; applies inputs for one rising edge
    task automatic step(input string tag, input bit we, input logic [31:0] w,
                        input bit at, input bit de, input bit ls);
        logic [31:0] nw;
        wr_en = we; wr_data = w; attach = at; detach = de; attach_low_speed = ls;
        nw = next_word(model, we, w, at, de, ls);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; attach = 1'b0; detach = 1'b0; attach_low_speed = 1'b0;
        compare(tag, nw, nw != model);
        model = nw;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset", 32'h0, 1'b0);

        step("R6 enable on empty port", 1, 32'h0000_0002, 0, 0, 0);
        step("R7 reset on empty port", 1, 32'h0000_0010, 0, 0, 0);
        step("R4 clear connect change", 1, 32'h0001_0000, 0, 0, 0);
        step("R9 no-op write", 1, 32'h0000_0000, 0, 0, 0);
        step("R8 power on", 1, 32'h0000_0100, 0, 0, 0);
        step("R2 attach low speed", 0, 32'h0, 1, 0, 1);
        step("R6 enable connected", 1, 32'h0000_0002, 0, 0, 0);
        step("R6 suspend connected", 1, 32'h0000_0004, 0, 0, 0);
        step("R5 clear enable", 1, 32'h0000_0001, 0, 0, 0);
        step("R7 reset connected", 1, 32'h0000_0010, 0, 0, 0);
        step("R4 clear all change", 1, 32'h001F_0000, 0, 0, 0);
        step("R3 detach enabled", 0, 32'h0, 0, 1, 0);
        step("R3 detach again", 0, 32'h0, 0, 1, 0);
        step("R2 attach full speed", 0, 32'h0, 1, 0, 0);
        step("R8 power off and on", 1, 32'h0000_0300, 0, 0, 0);
        step("R8 power off", 1, 32'h0000_0200, 0, 0, 0);
        step("R10 write with attach", 1, 32'h0000_0212, 1, 0, 1);
        step("R10 write with detach", 1, 32'h0000_0002, 0, 1, 0);
        step("R10 attach and detach", 1, 32'h0000_0006, 1, 1, 0);
        step("R11 write all ones", 1, 32'hFFFF_FFFF, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            bit we, at, de, ls;
            w  = $urandom & 32'h001F_0317;
            if (($urandom % 8) == 0) w = $urandom;
            we = ($urandom % 2) == 0;
            at = ($urandom % 6) == 0;
            de = ($urandom % 6) == 0;
            ls = $urandom % 2;
            step("R10 random", we, w, at, de, ls);
        end

        summary();
    end

endmodule